// File: doc/BRIEF.md
# Fractional Clock Ratio Enable Generator

This block runs on the fast pipeline clock and emits a single-cycle enable on every pipeline cycle that lines up with an edge of the slower bus-interface clock. Logic in the bus-interface domain is clocked by the pipeline clock and advances only when this enable is high. The bus clock runs at the master input rate, and the pipeline clock is that rate multiplied by the selected ratio.

The ratio is selected by a mode code. The code is sampled while reset is held and frozen when reset is released. A variant input picks one of two code tables: a narrow one that uses two code bits and a wide one that uses three. Integer ratios come out as one pulse per period. The half-integer ratios 1.5 and 2.5 come out as a fixed pattern of two pulses per period.

Some codes are never legal. Others are legal only on one speed grade, and a parameter selects that grade. Any such code raises a sticky error flag, and the block then falls back to the 2:1 ratio. A phase count output gives the position inside the current pattern period.

Top module: `frac_clk_en`

## Requirements
- R1: With `wide_code`=0 only `mode_code[1:0]` is decoded, and `mode_code[2]` has no effect. The ratios, written as pipeline cycles:bus pulses, are 00→4:1, 01→3:2, 10→2:1 and 11→3:1.
- R2: With `wide_code`=1 the full `mode_code[2:0]` is decoded: 000→5:1, 001→6:1, 010→5:2, 011→3:1, 100→4:1, 110→2:1 and 111→3:1. Code 101 is reserved.
- R3: For an integer ratio N:1, `phase` counts 0,1,…,N-1 and then wraps to 0. `bus_en` is high exactly when `phase`=0. The first pulse falls on the first cycle after reset is released.
- R4: For 3:2, `phase` cycles through 0,1,2 and `bus_en` follows the pattern 1,1,0.
- R5: For 5:2, `phase` cycles through 0..4 and `bus_en` follows the pattern 1,0,1,0,0, which gives two pulses every five cycles.
- R6: With `FAST_GRADE`=1, narrow code 01 is illegal. With `FAST_GRADE`=0, narrow code 00 and wide code 010 are illegal. Wide code 101 is illegal on both grades.
- R7: An illegal code sets `cfg_err`=1 and gives the 2:1 ratio.
- R8: The mode is captured on the last clock edge that sees reset high. Changes to `mode_code` or `wide_code` after that edge alter neither the ratio nor `cfg_err` until the next reset. A reset with a legal code clears `cfg_err`.
- R9: While `rst` is high, `bus_en`=0 and `phase`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst | input | 1 | Synchronous reset, active high; the mode is sampled while it is high |
| mode_code | input | 3 | Ratio select code |
| wide_code | input | 1 | 0 selects the two-bit table, 1 selects the three-bit table |
| bus_en | output | 1 | One-cycle enable marking a bus-clock edge |
| phase | output | 3 | Position inside the current ratio period |
| cfg_err | output | 1 | Sticky flag set by an illegal or grade-illegal code |

## Verification
The bench builds two copies of the block side by side, one with `FAST_GRADE`=1 and one with `FAST_GRADE`=0. Both grade legality tables are therefore checked against the same stimulus. All sixteen combinations of `wide_code` and `mode_code` are swept, including the narrow codes with the ignored high bit set. Each run lasts 60 cycles, a common multiple of every period, so the pulse count must equal the exact ratio and every cycle's `bus_en` and `phase` are compared with an arithmetic pattern. The mode inputs are changed partway through each run to show that the captured ratio holds.

// File: rtl/frac_clk_pkg.sv
package frac_clk_pkg;
   // Longest pattern period in pipeline cycles
   localparam int MAX_PCYC = 6;
   localparam int PCW      = $clog2(MAX_PCYC + 1);

   typedef struct packed {
      logic [PCW-1:0] pcyc;   // pipeline cycles per pattern period
      logic           two;    // two pulses per period (half-integer ratio)
   } ratio_t;

   localparam ratio_t FALLBACK = '{pcyc: PCW'(2), two: 1'b0};
endpackage

// File: rtl/frac_clk_decode.sv
module frac_clk_decode
   import frac_clk_pkg::*;
#(
   parameter bit FAST_GRADE = 1'b1
) (
   input  logic [2:0] code,
   input  logic       wide,
   output ratio_t     ratio,
   output logic       illegal
);
   logic grade_rsv;
   logic base_rsv;
   ratio_t raw;

   // The speed grade decides which codes are masked off
   generate
      if (FAST_GRADE) begin : g_fast
         assign grade_rsv = !wide && (code[1:0] == 2'b01);
      end else begin : g_slow
         assign grade_rsv = (!wide && (code[1:0] == 2'b00)) ||
                            ( wide && (code == 3'b010));
      end
   endgenerate

   always_comb begin
      raw      = FALLBACK;
      base_rsv = 1'b0;
      if (!wide) begin
         case (code[1:0])
            2'b00:   raw.pcyc = PCW'(4);
            2'b01:   begin raw.pcyc = PCW'(3); raw.two = 1'b1; end
            2'b10:   raw.pcyc = PCW'(2);
            default: raw.pcyc = PCW'(3);
         endcase
      end else begin
         case (code)
            3'b000:  raw.pcyc = PCW'(5);
            3'b001:  raw.pcyc = PCW'(6);
            3'b010:  begin raw.pcyc = PCW'(5); raw.two = 1'b1; end
            3'b011:  raw.pcyc = PCW'(3);
            3'b100:  raw.pcyc = PCW'(4);
            3'b101:  base_rsv = 1'b1;
            3'b110:  raw.pcyc = PCW'(2);
            default: raw.pcyc = PCW'(3);
         endcase
      end
   end

   assign illegal = base_rsv || grade_rsv;
   assign ratio   = illegal ? FALLBACK : raw;
endmodule

// File: rtl/frac_clk_cfg.sv
module frac_clk_cfg
   import frac_clk_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  ratio_t ratio_d,
   input  logic   err_d,
   output ratio_t ratio_q,
   output logic   err_q
);
   // Follows the decoded code while reset is high, then frozen
   always_ff @(posedge clk) begin
      if (rst) begin
         ratio_q <= ratio_d;
         err_q   <= err_d;
      end
   end
endmodule

// File: rtl/frac_clk_phase.sv
module frac_clk_phase
   import frac_clk_pkg::*;
(
   input  logic           clk,
   input  logic           rst,
   input  ratio_t         ratio,
   output logic [PCW-1:0] phase,
   output logic           en
);
   logic           run;
   logic [PCW-1:0] last;
   logic [PCW-1:0] mid;

   assign last = ratio.pcyc - PCW'(1);
   assign mid  = ratio.pcyc >> 1;

   always_ff @(posedge clk) begin
      if (rst) begin
         run   <= 1'b0;
         phase <= '0;
      end else begin
         run <= 1'b1;
         if (run) phase <= (phase == last) ? '0 : phase + PCW'(1);
      end
   end

   // Second pulse of a half-integer ratio lands at floor(period/2)
   assign en = run && ((phase == '0) || (ratio.two && (phase == mid)));
endmodule

// File: rtl/frac_clk_en.sv
module frac_clk_en
   import frac_clk_pkg::*;
#(
   parameter bit FAST_GRADE = 1'b1,
   parameter int CODE_W     = 3,
   parameter int PHASE_W    = 3
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [CODE_W-1:0]  mode_code,
   input  logic               wide_code,
   output logic               bus_en,
   output logic [PHASE_W-1:0] phase,
   output logic               cfg_err
);
   generate
      if (CODE_W != 3) begin : g_bad_code_w
         $error("frac_clk_en: CODE_W must be 3");
      end
      if (PHASE_W < PCW) begin : g_bad_phase_w
         $error("frac_clk_en: PHASE_W too narrow for the longest period");
      end
   endgenerate

   ratio_t         dec_ratio, cur_ratio;
   logic           dec_err;
   logic [PCW-1:0] ph;

   frac_clk_decode #(.FAST_GRADE(FAST_GRADE)) u_dec (
      .code    (mode_code[2:0]),
      .wide    (wide_code),
      .ratio   (dec_ratio),
      .illegal (dec_err)
   );

   frac_clk_cfg u_cfg (
      .clk     (clk),
      .rst     (rst),
      .ratio_d (dec_ratio),
      .err_d   (dec_err),
      .ratio_q (cur_ratio),
      .err_q   (cfg_err)
   );

   frac_clk_phase u_ph (
      .clk   (clk),
      .rst   (rst),
      .ratio (cur_ratio),
      .phase (ph),
      .en    (bus_en)
   );

   assign phase = PHASE_W'(ph);
endmodule

// File: rtl/frac_clk_en_chk.sv
module frac_clk_en_chk (
   input logic       clk,
   input logic       rst,
   input logic       bus_en,
   input logic [2:0] phase,
   input logic       cfg_err
);
   // R3
   phase_step_chk: assert property (@(posedge clk) disable iff (rst)
      (phase != 3'd0) |-> (phase == $past(phase) + 3'd1));

   // R3
   phase_zero_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      ((phase == 3'd0) && !$past(rst)) |-> bus_en);

   // R3
   phase_bound_chk: assert property (@(posedge clk) disable iff (rst)
      phase <= 3'd5);

   // R7
   fallback_ratio_chk: assert property (@(posedge clk) disable iff (rst)
      cfg_err |-> (phase <= 3'd1));

   // R8
   err_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !rst |=> $stable(cfg_err));
endmodule

bind frac_clk_en frac_clk_en_chk u_chk (
   .clk     (clk),
   .rst     (rst),
   .bus_en  (bus_en),
   .phase   (phase),
   .cfg_err (cfg_err)
);

// File: tb/tb_frac_clk_en.sv
module tb_frac_clk_en;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] mode_code = 3'b010;
   logic       wide_code = 1'b0;
   logic       en_f, en_s, err_f, err_s;
   logic [2:0] ph_f, ph_s;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   frac_clk_en #(.FAST_GRADE(1'b1)) dut (
      .clk(clk), .rst(rst), .mode_code(mode_code), .wide_code(wide_code),
      .bus_en(en_f), .phase(ph_f), .cfg_err(err_f));

   frac_clk_en #(.FAST_GRADE(1'b0)) dut_slow (
      .clk(clk), .rst(rst), .mode_code(mode_code), .wide_code(wide_code),
      .bus_en(en_s), .phase(ph_s), .cfg_err(err_s));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Expected ratio from the requirement tables (R1, R2, R6, R7)
   task automatic expect_ratio(input bit fast, input bit wide, input logic [2:0] c,
                               output int p, output int b, output bit e);
      p = 2; b = 1; e = 1'b0;
      if (!wide) begin
         case (c[1:0])
            2'b00: if (fast) p = 4; else e = 1'b1;
            2'b01: if (fast) e = 1'b1; else begin p = 3; b = 2; end
            2'b10: p = 2;
            default: p = 3;
         endcase
      end else begin
         case (c)
            3'b000: p = 5;
            3'b001: p = 6;
            3'b010: if (fast) begin p = 5; b = 2; end else e = 1'b1;
            3'b011: p = 3;
            3'b100: p = 4;
            3'b101: e = 1'b1;
            3'b110: p = 2;
            default: p = 3;
         endcase
      end
   endtask

   task automatic run_case(input bit wide, input logic [2:0] c);
      int p[2], b[2], cnt[2];
      bit e[2];
      string tag[2];
      string ctag;
      expect_ratio(1'b1, wide, c, p[0], b[0], e[0]);
      expect_ratio(1'b0, wide, c, p[1], b[1], e[1]);
      ctag = wide ? "R2" : "R1";
      for (int d = 0; d < 2; d++) begin
         cnt[d] = 0;
         if (e[d]) tag[d] = "R7";
         else if (b[d] == 2) tag[d] = (p[d] == 3) ? "R4" : "R5";
         else tag[d] = "R3";
      end
      rst = 1'b1; wide_code = wide; mode_code = c;
      repeat (3) @(negedge clk);
      // R9: quiet outputs during reset
      chk(!en_f && ph_f == 3'd0, "R9", int'(en_f), 0);
      chk(!en_s && ph_s == 3'd0, "R9", int'(en_s), 0);
      rst = 1'b0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         for (int d = 0; d < 2; d++) begin
            int  m = i % p[d];
            bit  xe = (m == 0) || (b[d] == 2 && m == p[d] / 2);
            bit  ae = (d == 0) ? en_f : en_s;
            int  ap = (d == 0) ? int'(ph_f) : int'(ph_s);
            chk(ae == xe, tag[d], int'(ae), int'(xe));
            chk(ap == m, tag[d], ap, m);
            if (ae) cnt[d]++;
         end
         // R8: disturb the mode inputs after capture
         if (i == 7) begin
            mode_code = ~c;
            wide_code = ~wide;
         end
      end
      for (int d = 0; d < 2; d++) begin
         int ae = (d == 0) ? int'(err_f) : int'(err_s);
         chk(cnt[d] == 60 * b[d] / p[d], ctag, cnt[d], 60 * b[d] / p[d]);
         // R6 / R7 / R8: flag from the captured code only
         chk(ae == int'(e[d]), "R6", ae, int'(e[d]));
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      for (int w = 0; w < 2; w++) begin
         for (int c = 0; c < 8; c++) begin
            run_case(w[0], c[2:0]);
         end
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule